// File: doc/BRIEF.md
# Indexed Configuration Space Controller

This block is the configuration front end of a multi-function peripheral. A host reaches it through a pair of byte-wide locations. Writing the address port picks a register. The data port then reads or writes the register that was picked. A small set of global registers sits beside a bank of per-function registers. One global register chooses which function's bank the data port currently reaches, so a single register index maps to different storage depending on that choice.

Each function has an activate flag and a 16-bit I/O base address. The block drives all of these as flat vectors, so downstream address decoders can enable and place each function. Besides these, the global set holds a fixed identity byte, a revision byte and ten general-purpose configuration bytes.

Top module: `cfg_space_ctrl`

## Requirements
- R1: A write with `host_addr`=0 loads `host_wdata` into the index register. A read with `host_addr`=0 returns the current index.
- R2: Index 0x20 always reads as the `CHIP_ID` parameter (default 0xE9). Writes to it have no effect.
- R3: Index 0x27 always reads as the `REV_ID` parameter. Writes to it have no effect.
- R4: A data write to index 0x07 with a value below `NUM_DEV` (default 15) selects that function number. Reading index 0x07 returns the selected number.
- R5: A data write to index 0x07 with a value of `NUM_DEV` or more is ignored, and the previous selection is kept.
- R6: A data write to index 0x30 stores bit 0 of the data as the activate flag of the selected function only. Reading index 0x30 returns that flag in bit 0, with bits 7..1 zero. `dev_enable[d]` mirrors function d's flag from the cycle after the write.
- R7: A data write to index 0x60 sets bits 15..8 of the selected function's base, and index 0x61 sets bits 7..0. Both read back. `dev_base[16*d +: 16]` carries function d's base from the cycle after the write.
- R8: Indices 0x21 to 0x25, 0x28 and 0x2A to 0x2D are independent read/write bytes.
- R9: Any other index ignores data writes and reads as 0x00. Such a write changes no implemented register and no output.
- R10: After reset, every function is inactive with base 0x0000. The index, the selection and the general bytes are all 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| host_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for the port selected by `host_addr` |
| dev_enable | output | NUM_DEV | Activate flag of each function |
| dev_base | output | 16*NUM_DEV | I/O base of each function, function d in bits 16*d+15..16*d |

## Verification
The bench sweeps all 256 index values, both straight after reset and again after every function has been programmed. A decoder that aliases an unimplemented index onto a real register would then read back the 0xA5 probe value or corrupt a neighbour. Each function gets a distinct activate flag and base pattern. Comparing the full output vectors exposes any banking fault, which would show up as a write landing in the wrong function or spreading to every function. Selection values at and above the function count (0x0F, 0x10, 0xFF) must leave the previous selection in place. A design that truncated the value to four bits would jump to function 15 or wrap to a low number, and later base reads would then return the wrong bank.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  // Register indices whose values the host software relies on
  localparam logic [7:0] IDX_DEV_SEL = 8'h07;
  localparam logic [7:0] IDX_CHIP_ID = 8'h20;
  localparam logic [7:0] IDX_REV     = 8'h27;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;

  localparam int GEN_COUNT = 10;
  localparam int GEN_SLOT_W = $clog2(GEN_COUNT);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CHIP_ID,
    SEL_REV,
    SEL_DEV_SEL,
    SEL_GEN,
    SEL_ACT,
    SEL_BASE_HI,
    SEL_BASE_LO
  } reg_sel_e;

  typedef struct packed {
    logic                  hit;
    logic [GEN_SLOT_W-1:0] slot;
  } gen_map_t;

  // Maps an index to one of the general-purpose byte slots
  function automatic gen_map_t gen_lookup(input logic [7:0] idx);
    gen_map_t m;
    m.hit  = 1'b1;
    m.slot = '0;
    case (idx)
      8'h21: m.slot = GEN_SLOT_W'(0);
      8'h22: m.slot = GEN_SLOT_W'(1);
      8'h23: m.slot = GEN_SLOT_W'(2);
      8'h24: m.slot = GEN_SLOT_W'(3);
      8'h25: m.slot = GEN_SLOT_W'(4);
      8'h28: m.slot = GEN_SLOT_W'(5);
      8'h2A: m.slot = GEN_SLOT_W'(6);
      8'h2B: m.slot = GEN_SLOT_W'(7);
      8'h2C: m.slot = GEN_SLOT_W'(8);
      8'h2D: m.slot = GEN_SLOT_W'(9);
      default: m.hit = 1'b0;
    endcase
    return m;
  endfunction

  function automatic reg_sel_e decode_index(input logic [7:0] idx);
    reg_sel_e s;
    case (idx)
      IDX_DEV_SEL: s = SEL_DEV_SEL;
      IDX_CHIP_ID: s = SEL_CHIP_ID;
      IDX_REV:     s = SEL_REV;
      IDX_ACT:     s = SEL_ACT;
      IDX_BASE_HI: s = SEL_BASE_HI;
      IDX_BASE_LO: s = SEL_BASE_LO;
      default:     s = gen_lookup(idx).hit ? SEL_GEN : SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_glob_regs.sv
module cfg_glob_regs
  import cfg_space_pkg::*;
#(
  parameter int NUM_DEV = 15,
  localparam int DEV_W = $clog2(NUM_DEV)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           idx_we,
  input  logic                           sel_we,
  input  logic                           gen_we,
  input  logic [GEN_SLOT_W-1:0]          gen_slot,
  input  logic [7:0]                     wdata,
  output logic [7:0]                     idx_q,
  output logic [DEV_W-1:0]               sel_q,
  output logic [GEN_COUNT-1:0][7:0]      gen_q
);

  localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

  logic [7:0]                idx_d;
  logic [DEV_W-1:0]          sel_d;
  logic                      sel_en;
  logic [GEN_COUNT-1:0][7:0] gen_d;

  always_comb begin
    idx_d  = wdata;
    sel_en = sel_we && (wdata < DEV_LIMIT);
    sel_d  = wdata[DEV_W-1:0];
    gen_d  = gen_q;
    if (gen_we) begin
      gen_d[gen_slot] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_we) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '0;
    end else if (gen_we) begin
      gen_q <= gen_d;
    end
  end

endmodule

// File: rtl/cfg_dev_slot.sv
module cfg_dev_slot (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        act_we,
  input  logic        hi_we,
  input  logic        lo_we,
  input  logic [7:0]  wdata,
  output logic        act_q,
  output logic [15:0] base_q
);

  logic        act_d;
  logic [15:0] base_d;
  logic        base_en;

  always_comb begin
    act_d   = wdata[0];
    base_en = hi_we | lo_we;
    base_d  = base_q;
    if (hi_we) base_d[15:8] = wdata;
    if (lo_we) base_d[7:0]  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (act_we) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
#(
  parameter int         NUM_DEV = 15,
  parameter logic [7:0] CHIP_ID = 8'hE9,
  parameter logic [7:0] REV_ID  = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_wr,
  input  logic                    host_addr,
  input  logic [7:0]              host_wdata,
  output logic [7:0]              host_rdata,
  output logic [NUM_DEV-1:0]      dev_enable,
  output logic [16*NUM_DEV-1:0]   dev_base
);

  localparam int DEV_W = $clog2(NUM_DEV);

  logic                      srst_n;
  logic [7:0]                idx_q;
  logic [DEV_W-1:0]          sel_q;
  logic [GEN_COUNT-1:0][7:0] gen_q;
  reg_sel_e                  reg_sel;
  gen_map_t                  gen_map;
  logic                      data_wr;
  logic                      idx_wr;
  logic [NUM_DEV-1:0]        act_w;
  logic [NUM_DEV-1:0][15:0]  base_w;
  logic [7:0]                reg_val;

  cfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    reg_sel = decode_index(idx_q);
    gen_map = gen_lookup(idx_q);
    data_wr = host_wr &  host_addr;
    idx_wr  = host_wr & ~host_addr;
  end

  cfg_glob_regs #(.NUM_DEV(NUM_DEV)) u_glob (
    .clk      (clk),
    .rst_n    (srst_n),
    .idx_we   (idx_wr),
    .sel_we   (data_wr && (reg_sel == SEL_DEV_SEL)),
    .gen_we   (data_wr && (reg_sel == SEL_GEN)),
    .gen_slot (gen_map.slot),
    .wdata    (host_wdata),
    .idx_q    (idx_q),
    .sel_q    (sel_q),
    .gen_q    (gen_q)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = data_wr && (sel_q == DEV_W'(d));

    cfg_dev_slot u_slot (
      .clk    (clk),
      .rst_n  (srst_n),
      .act_we (hit && (reg_sel == SEL_ACT)),
      .hi_we  (hit && (reg_sel == SEL_BASE_HI)),
      .lo_we  (hit && (reg_sel == SEL_BASE_LO)),
      .wdata  (host_wdata),
      .act_q  (act_w[d]),
      .base_q (base_w[d])
    );

    assign dev_enable[d]          = act_w[d];
    assign dev_base[16*d +: 16]   = base_w[d];
  end

  always_comb begin
    reg_val = '0;
    case (reg_sel)
      SEL_CHIP_ID: reg_val = CHIP_ID;
      SEL_REV:     reg_val = REV_ID;
      SEL_DEV_SEL: reg_val = 8'(sel_q);
      SEL_GEN:     reg_val = gen_q[gen_map.slot];
      SEL_ACT:     reg_val = {7'b0, act_w[sel_q]};
      SEL_BASE_HI: reg_val = base_w[sel_q][15:8];
      SEL_BASE_LO: reg_val = base_w[sel_q][7:0];
      default:     reg_val = '0;
    endcase
    host_rdata = host_addr ? reg_val : idx_q;
  end

endmodule

// File: rtl/cfg_space_ctrl_chk.sv
module cfg_space_ctrl_chk #(
  parameter int         NUM_DEV = 15,
  parameter logic [7:0] CHIP_ID = 8'hE9,
  localparam int        DEV_W   = $clog2(NUM_DEV)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  host_wr,
  input logic                  host_addr,
  input logic [7:0]            host_wdata,
  input logic [7:0]            host_rdata,
  input logic [7:0]            idx_q,
  input logic [DEV_W-1:0]      sel_q,
  input logic [NUM_DEV-1:0]    dev_enable,
  input logic [16*NUM_DEV-1:0] dev_base
);

  localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

  assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr) |=> (idx_q == $past(host_wdata)));

  assert_chip_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr && idx_q == 8'h20) |-> (host_rdata == CHIP_ID));

  assert_bad_select_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr && idx_q == 8'h07 && host_wdata >= DEV_LIMIT) |=> $stable(sel_q));

  assert_enable_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr && idx_q == 8'h30) |=> $stable(dev_enable));

  assert_enable_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_enable ^ $past(dev_enable)) <= 1);

  assert_base_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr && (idx_q == 8'h60 || idx_q == 8'h61)) |=> $stable(dev_base));

endmodule

bind cfg_space_ctrl cfg_space_ctrl_chk #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)) u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .idx_q      (idx_q),
  .sel_q      (sel_q),
  .dev_enable (dev_enable),
  .dev_base   (dev_base)
);

// File: tb/cfg_space_ctrl_tb.sv
module cfg_space_ctrl_tb;

  localparam int         ND   = 15;
  localparam logic [7:0] CHIP = 8'hE9;
  localparam logic [7:0] REV  = 8'h5A;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              host_wr;
  logic              host_addr;
  logic [7:0]        host_wdata;
  logic [7:0]        host_rdata;
  logic [ND-1:0]     dev_enable;
  logic [16*ND-1:0]  dev_base;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [ND-1:0]    exp_en;
  logic [16*ND-1:0] exp_base;
  logic [7:0]       exp_gen [256];

  always #2 clk = ~clk;

  cfg_space_ctrl #(.NUM_DEV(ND), .CHIP_ID(CHIP), .REV_ID(REV)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .dev_enable (dev_enable),
    .dev_base   (dev_base)
  );

  function automatic bit is_gen(input int i);
    return (i >= 8'h21 && i <= 8'h25) || i == 8'h28 || (i >= 8'h2A && i <= 8'h2D);
  endfunction

  function automatic logic [7:0] fixed_val(input int i);
    if (i == 8'h20) return CHIP;
    if (i == 8'h27) return REV;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    host_wr = 1'b0; host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic rd_idx(input logic [7:0] i, output logic [7:0] v);
    wr(1'b0, i);
    rd(1'b1, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; host_wr = 1'b0; host_addr = 1'b0; host_wdata = '0;
    exp_en = '0; exp_base = '0;
    for (int i = 0; i < 256; i++) exp_gen[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10: outputs held at reset values
    chk("R10 enable", 256'(dev_enable), 256'(0));
    chk("R10 base", 256'(dev_base), 256'(0));
    chk("R10 index", 256'(host_rdata), 256'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10/R2/R3/R9: every index after reset
    for (int i = 0; i < 256; i++) begin
      rd_idx(8'(i), v);
      chk("R10 sweep", 256'(v), 256'(fixed_val(i)));
      rd(1'b0, v);
      chk("R1 index readback", 256'(v), 256'(i));
    end

    // R4/R6/R7: program each function with its own pattern
    for (int d = 0; d < ND; d++) begin
      logic [7:0] hi, lo;
      hi = 8'(d * 17 + 3);
      lo = 8'(255 - d * 13);
      wr(1'b0, 8'h07); wr(1'b1, 8'(d));
      rd(1'b1, v);
      chk("R4 select", 256'(v), 256'(d));
      wr(1'b0, 8'h30); wr(1'b1, (d % 2 == 1) ? 8'hFF : 8'hFE);
      wr(1'b0, 8'h60); wr(1'b1, hi);
      wr(1'b0, 8'h61); wr(1'b1, lo);
      exp_en[d] = (d % 2 == 1);
      exp_base[16*d +: 16] = {hi, lo};
      chk("R6 enable vector", 256'(dev_enable), 256'(exp_en));
      chk("R7 base vector", 256'(dev_base), 256'(exp_base));
    end

    // R6/R7: banked readback
    for (int d = 0; d < ND; d++) begin
      wr(1'b0, 8'h07); wr(1'b1, 8'(d));
      rd_idx(8'h30, v);
      chk("R6 act readback", 256'(v), 256'({7'b0, exp_en[d]}));
      rd_idx(8'h60, v);
      chk("R7 base hi", 256'(v), 256'(exp_base[16*d+8 +: 8]));
      rd_idx(8'h61, v);
      chk("R7 base lo", 256'(v), 256'(exp_base[16*d +: 8]));
    end

    // R5: out-of-range selections keep function 4
    wr(1'b0, 8'h07); wr(1'b1, 8'd4);
    foreach (exp_gen[k]) begin end
    for (int j = 0; j < 3; j++) begin
      logic [7:0] bad;
      bad = (j == 0) ? 8'h0F : (j == 1) ? 8'h10 : 8'hFF;
      wr(1'b0, 8'h07); wr(1'b1, bad);
      rd(1'b1, v);
      chk("R5 select kept", 256'(v), 256'(4));
      rd_idx(8'h60, v);
      chk("R5 bank kept", 256'(v), 256'(exp_base[16*4+8 +: 8]));
    end

    // R8: general bytes
    for (int i = 0; i < 256; i++) begin
      if (is_gen(i)) begin
        wr(1'b0, 8'(i)); wr(1'b1, 8'(8'h3C ^ i));
        exp_gen[i] = 8'(8'h3C ^ i);
      end
    end
    for (int i = 0; i < 256; i++) begin
      if (is_gen(i)) begin
        rd_idx(8'(i), v);
        chk("R8 general byte", 256'(v), 256'(exp_gen[i]));
      end
    end

    // R9/R2/R3: writes to every other index are ignored
    for (int i = 0; i < 256; i++) begin
      if (!is_gen(i) && i != 8'h07 && i != 8'h30 && i != 8'h60 && i != 8'h61) begin
        wr(1'b0, 8'(i)); wr(1'b1, 8'hA5);
        rd(1'b1, v);
        chk((i == 8'h20) ? "R2 chip id" : (i == 8'h27) ? "R3 revision" : "R9 ignored",
            256'(v), 256'(fixed_val(i)));
      end
    end
    chk("R9 enable untouched", 256'(dev_enable), 256'(exp_en));
    chk("R9 base untouched", 256'(dev_base), 256'(exp_base));
    rd_idx(8'h07, v);
    chk("R9 select untouched", 256'(v), 256'(4));
    for (int i = 0; i < 256; i++) begin
      if (is_gen(i)) begin
        rd_idx(8'(i), v);
        chk("R9 general untouched", 256'(v), 256'(exp_gen[i]));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule